// File: doc/BRIEF.md
# DDR SDRAM command sequencer

This block sits on the controller side of a four-bank DDR SDRAM and turns single read or write requests into the command sequence the device expects. A request carries a bank, a row, a column, a direction and an auto-precharge flag, and it is taken over a valid/ready handshake. The sequencer keeps the open row of every bank. Several banks can hold open rows at once, so a request that lands on an already open row goes straight to the column command. A request to an idle bank first opens the row. A request to a bank that has a different row open first closes that row and then opens the new one.

Commands leave on a registered bus made of the four active-low strobes, the bank address and the shared address lines. The device samples this bus on the rising clock edge. Timing gaps between commands come from one down-counter that is reloaded from parameters: precharge-to-activate, activate-to-column, refresh cycle time and the recovery after an auto-precharged burst. A free-running interval timer raises a refresh request. This request takes precedence over new work. If any bank is open when the refresh is served, one precharge-all is issued first, and then the auto refresh.

The control is one state machine with these states:
- S_IDLE takes requests or starts a refresh.
- S_PRE closes a single bank, and S_PRE_WAIT holds it for the precharge gap.
- S_ACT opens a row, and S_ACT_WAIT holds it for the activate-to-column gap.
- S_COL issues the read or write. S_AP_WAIT holds the recovery after an auto-precharged burst.
- S_PREALL closes every bank, and S_PREALL_WAIT holds it for the precharge gap.
- S_REF issues the refresh, and S_REF_WAIT holds it for the refresh cycle time.

The transitions are:
- S_IDLE goes to S_PREALL or S_REF when a refresh is pending. Otherwise, with a request, it goes to S_COL on a hit, to S_PRE on a row miss, and to S_ACT on an idle bank.
- Every command state enters its wait state.
- S_PRE_WAIT goes to S_ACT, S_ACT_WAIT to S_COL, and S_PREALL_WAIT to S_REF.
- S_COL goes to S_AP_WAIT when auto precharge was requested, and to S_IDLE otherwise.
- S_AP_WAIT and S_REF_WAIT return to S_IDLE.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During reset and in the first cycle after it, the bus carries NOP with bank and address zero, and `req_ready` is high once reset is released.
- R2: Command codes on {cs_n, ras_n, cas_n, we_n} are NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001.
- R3: A request to an idle bank issues ACTIVE with that bank and the row on A[12:0]. The column command follows exactly T_RCD cycles later.
- R4: A request whose row equals the row already open in its bank issues only the column command (READ when `req_write` is 0, WRITE when it is 1).
- R5: A request to a bank with a different row open issues PRECHARGE to that bank with A[12:0] all zero, and ACTIVE follows exactly T_RP cycles later.
- R6: A column command carries the column on A[9:0], column bit 10 on A11, column bit 11 on A12 (zero where the column is narrower) and the auto-precharge flag on A10.
- R7: After a column command with A10 high, that bank counts as idle: its next request starts with ACTIVE and no PRECHARGE. No command follows within T_AP cycles.
- R8: Each of the four banks keeps its own open row, so reopening a row in one bank does not disturb the rows held by the others.
- R9: AUTO REFRESH is issued once per REF_INT cycles. Consecutive refreshes lie within REF_INT plus or minus the longest request sequence.
- R10: AUTO REFRESH is issued only with all banks idle. If any bank is open, a PRECHARGE with A10 high comes exactly T_RP cycles before it, and if none is open, no such precharge is issued.
- R11: No command follows AUTO REFRESH for at least T_RFC cycles.
- R12: A pending refresh holds `req_ready` low, is never inserted inside a request's sequence, and is not starved by a continuous stream of requests.
- R13: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low in the cycle after an acceptance, and no command appears without a request or a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; the bus is updated on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column of the burst |
| req_ap | input | 1 | Close the row automatically after the burst |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ROW_W | Row, column or precharge-all address |

## Verification
A refresh that falls due and a request that is valid in the same idle cycle compete, and the refresh must win. The bench provokes this by holding a stream of hit requests on one bank back to back for more than two refresh intervals. Every idle cycle then sees a valid request, and refreshes become due while requests are in flight. The bench judges the result in three ways. At least two refreshes must appear during the stream. No refresh or precharge-all may appear while the bench still expects commands of an accepted request. Each refresh must keep its interval bound.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Command codes on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_PRE_WAIT,
        S_ACT,
        S_ACT_WAIT,
        S_COL,
        S_AP_WAIT,
        S_PREALL,
        S_PREALL_WAIT,
        S_REF,
        S_REF_WAIT
    } seq_state_e;

endpackage

// File: rtl/bank_row_table.sv
module bank_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic [BANK_W-1:0] open_bank,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              close_en,
    input  logic [BANK_W-1:0] close_bank,
    input  logic              close_all,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row,
    output logic              any_open
);
    localparam int BANKS = 1 << BANK_W;

    logic [BANKS-1:0] vld_q;
    logic [ROW_W-1:0] row_q [BANKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < BANKS; i++) begin
                row_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < BANKS; i++) begin
                if (close_all) begin
                    vld_q[i] <= 1'b0;
                end else if (open_en && open_bank == BANK_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    row_q[i] <= open_row;
                end else if (close_en && close_bank == BANK_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    assign look_open = vld_q[look_bank];
    assign look_row  = row_q[look_bank];
    assign any_open  = |vld_q;

    // R10: a close-all leaves no bank open in the following cycle
    p_close_all_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        close_all |=> !any_open);

    // R8: opening one bank keeps every other bank's state
    p_open_keeps_others_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (open_en && !close_all && !close_en) |=> ($countones(vld_q) >= $countones($past(vld_q))));

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R11: a non-zero load always produces at least one waiting cycle
    p_load_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done);

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int REF_INT = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int RW = $clog2(REF_INT);

    logic [RW-1:0] cnt_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= RW'(REF_INT - 1);
            pend_q <= 1'b0;
        end else begin
            if (cnt_q == '0) begin
                cnt_q  <= RW'(REF_INT - 1);
                pend_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
                if (ack) begin
                    pend_q <= 1'b0;
                end
            end
        end
    end

    assign pend = pend_q;

    // R12: a pending refresh stays pending until it is served
    p_pending_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int BANK_W  = 2,
    parameter int T_RP    = 3,
    parameter int T_RCD   = 3,
    parameter int T_RFC   = 10,
    parameter int T_AP    = 5,
    parameter int REF_INT = 1560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [BANK_W-1:0] cmd_ba,
    output logic [ROW_W-1:0]  cmd_addr
);
    localparam int T_MAX1 = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int T_MAX2 = (T_RFC > T_AP) ? T_RFC : T_AP;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int CW     = $clog2(T_MAX + 1);
    localparam int CPAD   = 12;

    seq_state_e state_q, state_d;

    logic [BANK_W-1:0] lat_bank;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              lat_wr;
    logic              lat_ap;

    logic              accept;
    logic              ref_pend;
    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic              any_open;
    logic [BANK_W-1:0] look_bank;
    logic              hit;
    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              tmr_done;

    logic [3:0]        cmd_d;
    logic [BANK_W-1:0] ba_d;
    logic [ROW_W-1:0]  addr_d;
    logic [CPAD-1:0]   col_pad;
    logic [12:0]       col_addr;

    // ---------------- helpers ----------------
    assign look_bank = (state_q == S_IDLE) ? req_bank : lat_bank;
    assign hit       = look_open && (look_row == req_row);
    assign req_ready = (state_q == S_IDLE) && !ref_pend;
    assign accept    = req_valid && req_ready;

    bank_row_table #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (state_q == S_ACT),
        .open_bank  (lat_bank),
        .open_row   (lat_row),
        .close_en   ((state_q == S_PRE) || (state_q == S_COL && lat_ap)),
        .close_bank (lat_bank),
        .close_all  (state_q == S_PREALL),
        .look_bank  (look_bank),
        .look_open  (look_open),
        .look_row   (look_row),
        .any_open   (any_open)
    );

    gap_timer #(
        .CW (CW)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    refresh_timer #(
        .REF_INT (REF_INT)
    ) u_refi (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (state_q == S_REF),
        .pend  (ref_pend)
    );

    // ---------------- request latch ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_bank <= '0;
            lat_row  <= '0;
            lat_col  <= '0;
            lat_wr   <= 1'b0;
            lat_ap   <= 1'b0;
        end else if (accept) begin
            lat_bank <= req_bank;
            lat_row  <= req_row;
            lat_col  <= req_col;
            lat_wr   <= req_write;
            lat_ap   <= req_ap;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (ref_pend) begin
                    state_d = any_open ? S_PREALL : S_REF;
                end else if (req_valid) begin
                    if (hit)            state_d = S_COL;
                    else if (look_open) state_d = S_PRE;
                    else                state_d = S_ACT;
                end
            end
            S_PRE:         state_d = S_PRE_WAIT;
            S_PRE_WAIT:    if (tmr_done) state_d = S_ACT;
            S_ACT:         state_d = S_ACT_WAIT;
            S_ACT_WAIT:    if (tmr_done) state_d = S_COL;
            S_COL:         state_d = lat_ap ? S_AP_WAIT : S_IDLE;
            S_AP_WAIT:     if (tmr_done) state_d = S_IDLE;
            S_PREALL:      state_d = S_PREALL_WAIT;
            S_PREALL_WAIT: if (tmr_done) state_d = S_REF;
            S_REF:         state_d = S_REF_WAIT;
            S_REF_WAIT:    if (tmr_done) state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // ---------------- gap timer loading ----------------
    // A load of T-2 in the command state puts the next command state T cycles later.
    always_comb begin
        tmr_load = 1'b1;
        tmr_val  = '0;
        unique case (state_q)
            S_PRE, S_PREALL: tmr_val = CW'(T_RP - 2);
            S_ACT:           tmr_val = CW'(T_RCD - 2);
            S_COL:           tmr_val = CW'(T_AP - 2);
            S_REF:           tmr_val = CW'(T_RFC - 2);
            default:         tmr_load = 1'b0;
        endcase
    end

    // ---------------- command outputs ----------------
    assign col_pad  = CPAD'(lat_col);
    assign col_addr = {col_pad[11], col_pad[10], lat_ap, col_pad[9:0]};

    always_comb begin
        cmd_d  = CMD_NOP;
        ba_d   = '0;
        addr_d = '0;
        unique case (state_q)
            S_PRE: begin
                cmd_d = CMD_PRE;
                ba_d  = lat_bank;
            end
            S_ACT: begin
                cmd_d  = CMD_ACT;
                ba_d   = lat_bank;
                addr_d = lat_row;
            end
            S_COL: begin
                cmd_d  = lat_wr ? CMD_WR : CMD_RD;
                ba_d   = lat_bank;
                addr_d = ROW_W'(col_addr);
            end
            S_PREALL: begin
                cmd_d  = CMD_PRE;
                addr_d = ROW_W'(13'h0400);
            end
            S_REF:   cmd_d = CMD_REF;
            default: cmd_d = CMD_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= CMD_NOP;
            cmd_ba   <= '0;
            cmd_addr <= '0;
        end else begin
            {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= cmd_d;
            cmd_ba   <= ba_d;
            cmd_addr <= addr_d;
        end
    end

    // ---------------- assertions ----------------
    // R4: a column command only ever targets the row the table holds open
    p_col_on_open_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COL) |-> (look_open && look_row == lat_row));

    // R3: ACTIVE is only issued to a bank the table holds idle
    p_act_on_idle_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACT) |-> !look_open);

    // R10: refresh only with every bank closed
    p_ref_all_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REF) |-> !any_open);

    // R13: after an acceptance the block is busy in the next cycle
    p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: the bus stays quiet while the refresh cycle time runs
    p_quiet_after_ref_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REF_WAIT) |=> ({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == CMD_NOP));

endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 12;
    localparam int BANK_W = 2;
    localparam int TRP    = 3;
    localparam int TRCD   = 2;
    localparam int TRFC   = 6;
    localparam int TAP    = 4;
    localparam int RINT   = 150;
    localparam int SLACK  = 2 * TRP + TRCD + TAP + 10;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_ap = 1'b0;
    logic              cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [BANK_W-1:0] cmd_ba;
    logic [ROW_W-1:0]  cmd_addr;

    always #4 clk = ~clk;

    sdram_cmd_seq #(
        .ROW_W (ROW_W), .COL_W (COL_W), .BANK_W (BANK_W),
        .T_RP (TRP), .T_RCD (TRCD), .T_RFC (TRFC), .T_AP (TAP), .REF_INT (RINT)
    ) u_sdram_cmd_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col), .req_ap (req_ap),
        .cmd_cs_n (cmd_cs_n), .cmd_ras_n (cmd_ras_n), .cmd_cas_n (cmd_cas_n), .cmd_we_n (cmd_we_n),
        .cmd_ba (cmd_ba), .cmd_addr (cmd_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int cyc      = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- bench model ----------------
    bit          mv [4];
    bit          apc [4];
    logic [12:0] mr [4];
    logic [3:0]  q_cmd [64];
    logic [1:0]  q_ba [64];
    logic [12:0] q_addr [64];
    string       q_tag [64];
    int          q_head = 0;
    int          q_tail = 0;

    task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                        input string tag);
        q_cmd[q_tail % 64]  = c;
        q_ba[q_tail % 64]   = b;
        q_addr[q_tail % 64] = a;
        q_tag[q_tail % 64]  = tag;
        q_tail++;
    endtask

    function automatic logic [12:0] col_a(input logic [11:0] col, input logic ap);
        return {col[11], col[10], ap, col[9:0]};
    endfunction

    task automatic send(input int b, input logic [12:0] row, input logic [11:0] col,
                        input bit wr, input bit ap);
        logic [3:0] cc;
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = 2'(b);
        req_row   = row;
        req_col   = col;
        req_write = wr;
        req_ap    = ap;
        while (!req_ready) @(negedge clk);
        cc = wr ? C_WR : C_RD;
        if (mv[b] && mr[b] == row) begin
            push(cc, 2'(b), col_a(col, ap), "R4");
        end else begin
            if (mv[b]) push(C_PRE, 2'(b), 13'd0, "R5");
            push(C_ACT, 2'(b), row, apc[b] ? "R7" : "R3");
            push(cc, 2'(b), col_a(col, ap), "R6");
        end
        mv[b]  = !ap;
        apc[b] = ap;
        mr[b]  = row;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R13", "ready after acceptance", req_ready, 0);
    endtask

    // ---------------- bus monitor ----------------
    int last_cyc  = 0;
    int last_kind = 0;   // 0 none, 1 PRE, 2 ACT, 3 COL, 4 PREALL, 5 REF
    bit last_ap   = 1'b0;
    int last_ref  = -1;
    int ref_cnt   = 0;
    int pall_cnt  = 0;

    always @(negedge clk) begin
        logic [3:0] c;
        int gap;
        int kind;
        int hi;
        bit anyo;
        if (rst_n && !finished) begin
            c = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
            if (c != C_NOP) begin
                gap  = cyc - last_cyc;
                kind = 0;
                anyo = mv[0] | mv[1] | mv[2] | mv[3];
                if (last_kind == 5)
                    check(gap >= TRFC, "R11", "gap after refresh", gap, TRFC);
                if (last_kind == 3 && last_ap)
                    check(gap >= TAP, "R7", "gap after auto-precharge burst", gap, TAP);
                if (c == C_PRE && cmd_addr[10]) begin
                    check(q_head == q_tail, "R12", "precharge-all inside a request", q_tail - q_head, 0);
                    check(anyo, "R10", "precharge-all with all banks idle", anyo, 1);
                    for (int i = 0; i < 4; i++) mv[i] = 1'b0;
                    pall_cnt++;
                    kind = 4;
                end else if (c == C_REF) begin
                    check(q_head == q_tail, "R12", "refresh inside a request", q_tail - q_head, 0);
                    check(!anyo, "R10", "refresh with a bank open", anyo, 0);
                    if (last_kind == 4)
                        check(gap == TRP, "R10", "precharge-all to refresh gap", gap, TRP);
                    if (last_ref >= 0)
                        check((cyc - last_ref) >= RINT - SLACK && (cyc - last_ref) <= RINT + SLACK,
                              "R9", "refresh spacing", cyc - last_ref, RINT);
                    last_ref = cyc;
                    ref_cnt++;
                    kind = 5;
                end else if (q_head == q_tail) begin
                    check(1'b0, "R13", "command without request", c, C_NOP);
                end else begin
                    hi = q_head % 64;
                    check(c == q_cmd[hi], "R2", {q_tag[hi], " command code"}, c, q_cmd[hi]);
                    check(cmd_ba == q_ba[hi], q_tag[hi], "bank address", cmd_ba, q_ba[hi]);
                    check(cmd_addr == q_addr[hi], q_tag[hi], "address lines", cmd_addr, q_addr[hi]);
                    if (c == C_ACT && last_kind == 1)
                        check(gap == TRP, "R5", "precharge to activate gap", gap, TRP);
                    if ((c == C_RD || c == C_WR) && last_kind == 2)
                        check(gap == TRCD, "R3", "activate to column gap", gap, TRCD);
                    q_head++;
                    if (c == C_PRE)      kind = 1;
                    else if (c == C_ACT) kind = 2;
                    else                 kind = 3;
                end
                last_ap   = (kind == 3) && cmd_addr[10];
                last_cyc  = cyc;
                last_kind = kind;
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R13 watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int r0, p0, t0;
        for (int i = 0; i < 4; i++) begin
            mv[i] = 1'b0; apc[i] = 1'b0; mr[i] = '0;
        end
        repeat (5) @(negedge clk);
        // R1: reset state on the bus
        check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == C_NOP, "R1", "bus in reset",
              {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, C_NOP);
        check(cmd_ba == 0, "R1", "bank in reset", cmd_ba, 0);
        check(cmd_addr == 0, "R1", "address in reset", cmd_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == C_NOP, "R1", "bus after reset",
              {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, C_NOP);

        // Sweep: misses, hits, idle opens, both directions, auto precharge
        for (int ap = 0; ap < 2; ap++)
            for (int row = 0; row < 3; row++)
                for (int b = 0; b < 4; b++)
                    for (int wr = 0; wr < 2; wr++)
                        send(b, 13'(row * 1000 + b * 7 + 1),
                             12'(b * 613 + row * 1171 + wr * 2053 + ap * 29), wr[0], ap[0]);

        // R10: with all banks idle a refresh comes without precharge-all
        while (q_head != q_tail) @(negedge clk);
        p0 = pall_cnt;
        r0 = ref_cnt;
        repeat (RINT + SLACK) @(negedge clk);
        check(ref_cnt > r0, "R9", "refresh count while idle", ref_cnt - r0, 1);
        check(pall_cnt == p0, "R10", "precharge-all while idle", pall_cnt - p0, 0);

        // R8: four banks hold rows at once; revisiting the first is a hit
        send(0, 13'd100, 12'h0a5, 1'b0, 1'b0);
        send(1, 13'd200, 12'h15a, 1'b1, 1'b0);
        send(2, 13'd300, 12'hc33, 1'b0, 1'b0);
        send(3, 13'd400, 12'h3cc, 1'b1, 1'b0);
        send(0, 13'd100, 12'h801, 1'b1, 1'b0);
        send(1, 13'd200, 12'h402, 1'b0, 1'b0);

        // R12: saturating request stream must not starve refresh
        r0 = ref_cnt;
        t0 = cyc;
        while (cyc < t0 + 2 * RINT + SLACK)
            send(2, 13'd300, 12'(cyc), cyc[0], 1'b0);
        check(ref_cnt - r0 >= 2, "R12", "refreshes during request stream", ref_cnt - r0, 2);

        while (q_head != q_tail) @(negedge clk);
        repeat (TRFC + 5) @(negedge clk);
        check(q_head == q_tail, "R13", "expected commands left over", q_tail - q_head, 0);
        finish_run();
    end

endmodule